// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital side of a successive-approximation analog-to-digital converter. It serves up to eight multiplexed inputs. It divides the bus clock into a conversion clock and steers the input multiplexer. For each conversion it drives a trial code to an external DAC, reads back a single comparator bit, and settles the result one bit at a time, starting at the most significant bit. Every conversion takes a fixed frame of conversion-clock periods. The finished code goes into a result slot for its channel, together with a done flag and an overrun flag.

Software programs the block through a small word-wide register port. A conversion can start in three ways. Software can start one directly. A selected edge on an external pin or on a timer-match line can start one. Or the block can scan a channel mask on its own in burst mode. The converter powers up disabled. It only runs while both an external power-gate input and its own enable bit are set, and that enable bit can only be raised while the gate is already on. An interrupt output reports finished results on channels the software has unmasked.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset the control word (address 0) and status word (address 2) read zero, `irq` is low and `dac_code` is zero.
- R2: The enable bit (control bit 17) only takes the value 1 when `pwr_gate` is high during the write. A low `pwr_gate` clears it on the next clock. The converter is active only while both are high.
- R3: Any start request (software, trigger or burst) made while the converter is not active is ignored, and no done flag appears.
- R4: A software start is a control write with start field (bits 19:18) equal to 01 and burst bit 16 clear. Its done flag appears exactly 65×(N+1) clocks after the write edge, where N is the divider field (bits 15:8).
- R5: The first trial code is the MSB alone. The stored result equals the largest code whose comparator answer was "input at or above trial", which is the input value for a monotone comparator.
- R6: A software or trigger start converts the lowest-numbered channel set in the mask field (bits 7:0).
- R7: With burst bit 16 set, the masked channels are converted repeatedly in ascending order, wrapping from the highest back to the lowest, with one idle clock between conversions. Clearing the bit lets the conversion in progress finish and starts no more.
- R8: Start field 10 selects the pin trigger and 11 the timer-match trigger. Polarity bit 20 selects the rising edge (0) or the falling edge (1). An edge of the other polarity, or one arriving while a conversion runs, starts nothing.
- R9: Result slot of channel c is at address 8+c: bits 11:0 hold the code, bit 31 is done and bit 30 is overrun. A result written over an unread one sets overrun. Reading the slot clears both flags. Status bits 7:0 mirror done, bits 15:8 mirror overrun, and bit 16 is busy.
- R10: `irq` is high exactly while some channel is done and has its bit set in the interrupt mask (address 1, bits 7:0).
- R11: Dropping the converter out of the active state during a conversion aborts it: no result is stored and `dac_code` returns to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| pwr_gate | input | 1 | Peripheral power gate from the system |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (clears flags of a result slot) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| cmp_in | input | 1 | Comparator: 1 when the selected input is at or above `dac_code` |
| dac_code | output | 12 | Trial code to the DAC, zero while idle |
| chan_sel | output | 3 | Multiplexer channel select |
| trig_pin | input | 1 | External pin trigger |
| trig_match | input | 1 | Timer-match trigger |
| irq | output | 1 | Interrupt request |

## Verification
The bench models the analog input as a per-channel code and answers the comparator from it. It then converts all-zero, all-one, mid-scale, just-below-mid-scale and alternating-bit inputs, which separates a wrong bit order, a stuck trial bit and an off-by-one bit decision. It times the done flag at two divider settings, one clock early and on time, to catch a frame or divider error. Burst scans over a sparse mask show the ascending order and the wrap. Repeated conversions without reads separate overrun from plain done. Trigger pulses of both polarities, and a second pulse during a conversion, show which edges start work.

// File: rtl/sar_pkg.sv
package sar_pkg;
   localparam int ADDR_W = 4;
   localparam int DATA_W = 32;

   localparam logic [ADDR_W-1:0] A_CTRL  = 4'h0;
   localparam logic [ADDR_W-1:0] A_IMASK = 4'h1;
   localparam logic [ADDR_W-1:0] A_STAT  = 4'h2;

   // control word field positions
   localparam int F_DIV_LSB  = 8;
   localparam int F_BURST    = 16;
   localparam int F_PON      = 17;
   localparam int F_MODE_LSB = 18;
   localparam int F_POL      = 20;

   // status word field positions
   localparam int S_OVR_LSB = 8;
   localparam int S_BUSY    = 16;
   localparam int S_IRQ     = 17;

   // result slot flag positions
   localparam int R_OVR  = 30;
   localparam int R_DONE = 31;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_NOW  = 2'b01,
      ST_PIN  = 2'b10,
      ST_TMR  = 2'b11
   } start_mode_e;
endpackage

// File: rtl/sar_clkdiv.sv
module sar_clkdiv #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] pre;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pre <= '0;
      else if (!run)       pre <= '0;
      else if (pre == div) pre <= '0;
      else                 pre <= pre + 1'b1;
   end

   assign tick = run && (pre == div);
endmodule

// File: rtl/sar_trig.sv
module sar_trig #(
   parameter bit SYNC = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_raw,
   input  logic falling,
   output logic edge_o
);
   logic s_in;
   logic prev;

   generate
      if (SYNC) begin : g_sync
         logic meta;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) meta <= 1'b0;
            else        meta <= in_raw;
         end
         assign s_in = meta;
      end else begin : g_direct
         assign s_in = in_raw;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= s_in;
   end

   assign edge_o = falling ? (prev & ~s_in) : (~prev & s_in);
endmodule

// File: rtl/sar_pick.sv
module sar_pick #(
   parameter int NCH = 8,
   localparam int CH_W = $clog2(NCH)
) (
   input  logic [NCH-1:0]  mask,
   input  logic [CH_W-1:0] last,
   output logic [CH_W-1:0] nxt,
   output logic            any
);
   always_comb begin
      logic [CH_W-1:0] idx;
      nxt = last;
      any = 1'b0;
      for (int i = 1; i <= NCH; i++) begin
         idx = last + CH_W'(i);
         if (!any && mask[idx]) begin
            any = 1'b1;
            nxt = idx;
         end
      end
   end
endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
   parameter int RES_W = 12,
   parameter int FRAME = 65,
   localparam int CNT_W = $clog2(FRAME)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             abort,
   input  logic             tick,
   input  logic             cmp_in,
   output logic             busy,
   output logic             fin,
   output logic [RES_W-1:0] code,
   output logic [RES_W-1:0] result
);
   localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

   logic [CNT_W-1:0] tcnt;
   logic [RES_W-1:0] appr;

   function automatic logic [RES_W-1:0] sar_step(input logic [RES_W-1:0] a,
                                                 input logic [CNT_W-1:0] t,
                                                 input logic keep);
      logic [RES_W-1:0] r;
      r = a;
      for (int i = 0; i < RES_W; i++) begin
         if (CNT_W'(RES_W - 1 - i) == t && !keep) r[i] = 1'b0;
      end
      for (int i = 0; i < RES_W - 1; i++) begin
         if (CNT_W'(RES_W - 2 - i) == t) r[i] = 1'b1;
      end
      return r;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         tcnt <= '0;
         appr <= '0;
      end else if (abort) begin
         busy <= 1'b0;
         tcnt <= '0;
         appr <= '0;
      end else if (start && !busy) begin
         busy <= 1'b1;
         tcnt <= '0;
         appr <= TOP_BIT;
      end else if (busy && tick) begin
         if (tcnt == CNT_W'(FRAME - 1)) begin
            busy <= 1'b0;
            tcnt <= '0;
         end else begin
            tcnt <= tcnt + 1'b1;
         end
         if (tcnt < CNT_W'(RES_W)) appr <= sar_step(appr, tcnt, cmp_in);
      end
   end

   assign fin    = busy && tick && (tcnt == CNT_W'(FRAME - 1));
   assign code   = busy ? appr : '0;
   assign result = appr;
endmodule

// File: rtl/sar_results.sv
module sar_results #(
   parameter int NCH   = 8,
   parameter int RES_W = 12,
   localparam int CH_W = $clog2(NCH)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [CH_W-1:0]           wr_ch,
   input  logic [RES_W-1:0]          wr_data,
   input  logic                      clr_en,
   input  logic [CH_W-1:0]           clr_ch,
   output logic [NCH-1:0][RES_W-1:0] res,
   output logic [NCH-1:0]            done,
   output logic [NCH-1:0]            ovr
);
   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               res[c]  <= '0;
               done[c] <= 1'b0;
               ovr[c]  <= 1'b0;
            end else if (wr_en && wr_ch == CH_W'(c)) begin
               res[c]  <= wr_data;
               done[c] <= 1'b1;
               ovr[c]  <= ovr[c] | done[c];
            end else if (clr_en && clr_ch == CH_W'(c)) begin
               done[c] <= 1'b0;
               ovr[c]  <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
   import sar_pkg::*;
#(
   parameter int NCH       = 8,
   parameter int RES_W     = 12,
   parameter int DIV_W     = 8,
   parameter int FRAME     = 65,
   parameter bit TRIG_SYNC = 1'b1,
   localparam int CH_W = $clog2(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_gate,
   input  logic              reg_we,
   input  logic              reg_re,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              cmp_in,
   output logic [RES_W-1:0]  dac_code,
   output logic [CH_W-1:0]   chan_sel,
   input  logic              trig_pin,
   input  logic              trig_match,
   output logic              irq
);
   // elaboration-time parameter checks
   generate
      if (NCH < 2 || NCH > 8 || (NCH & (NCH - 1)) != 0) begin : g_bad_nch
         $error("NCH must be a power of two from 2 to 8");
      end
      if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
         $error("DIV_W must be from 1 to 8");
      end
      if (RES_W < 2 || RES_W > 16) begin : g_bad_res
         $error("RES_W must be from 2 to 16");
      end
      if (FRAME <= RES_W) begin : g_bad_frame
         $error("FRAME must exceed RES_W");
      end
   endgenerate

   // control state
   logic [NCH-1:0]   mask_q;
   logic [DIV_W-1:0] div_q;
   logic             burst_q;
   logic             pon_q;
   start_mode_e      mode_q;
   logic             pol_q;
   logic [NCH-1:0]   imask_q;
   logic [CH_W-1:0]  last_ch;
   logic [CH_W-1:0]  cur_ch;

   logic wr_ctrl, wr_imask;
   logic enabled;
   start_mode_e wmode;
   logic unused_wbits;

   assign wr_ctrl  = reg_we && (reg_addr == A_CTRL);
   assign wr_imask = reg_we && (reg_addr == A_IMASK);
   assign enabled  = pwr_gate && pon_q;
   assign wmode    = start_mode_e'(reg_wdata[F_MODE_LSB +: 2]);
   assign unused_wbits = ^{reg_wdata[DATA_W-1:F_POL+1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '0;
         div_q   <= '0;
         burst_q <= 1'b0;
         pon_q   <= 1'b0;
         mode_q  <= ST_IDLE;
         pol_q   <= 1'b0;
         imask_q <= '0;
      end else begin
         if (wr_ctrl) begin
            mask_q  <= reg_wdata[NCH-1:0];
            div_q   <= reg_wdata[F_DIV_LSB +: DIV_W];
            burst_q <= reg_wdata[F_BURST];
            pon_q   <= reg_wdata[F_PON] & pwr_gate;
            mode_q  <= (wmode == ST_NOW) ? ST_IDLE : wmode;
            pol_q   <= reg_wdata[F_POL];
         end
         if (!pwr_gate) pon_q <= 1'b0;
         if (wr_imask) imask_q <= reg_wdata[NCH-1:0];
      end
   end

   // triggers
   logic pin_edge, tmr_edge;

   sar_trig #(.SYNC(TRIG_SYNC)) u_trig_pin (
      .clk(clk), .rst_n(rst_n), .in_raw(trig_pin), .falling(pol_q), .edge_o(pin_edge)
   );
   sar_trig #(.SYNC(TRIG_SYNC)) u_trig_tmr (
      .clk(clk), .rst_n(rst_n), .in_raw(trig_match), .falling(pol_q), .edge_o(tmr_edge)
   );

   // channel choice
   logic [NCH-1:0]  pick_mask;
   logic [CH_W-1:0] pick_from;
   logic [CH_W-1:0] pick_ch;
   logic            pick_any;

   assign pick_mask = wr_ctrl ? reg_wdata[NCH-1:0] : mask_q;
   assign pick_from = (burst_q && !wr_ctrl) ? last_ch : {CH_W{1'b1}};

   sar_pick #(.NCH(NCH)) u_pick (
      .mask(pick_mask), .last(pick_from), .nxt(pick_ch), .any(pick_any)
   );

   // start arbitration
   logic busy, fin, tick, go;
   logic sw_go, pin_go, tmr_go, burst_go;
   logic [RES_W-1:0] conv_res;

   assign sw_go    = wr_ctrl && (wmode == ST_NOW) && !reg_wdata[F_BURST];
   assign pin_go   = !wr_ctrl && !burst_q && (mode_q == ST_PIN) && pin_edge;
   assign tmr_go   = !wr_ctrl && !burst_q && (mode_q == ST_TMR) && tmr_edge;
   assign burst_go = !wr_ctrl && burst_q;
   assign go       = enabled && !busy && pick_any && (sw_go || pin_go || tmr_go || burst_go);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_ch <= {CH_W{1'b1}};
         cur_ch  <= '0;
      end else if (go) begin
         last_ch <= pick_ch;
         cur_ch  <= pick_ch;
      end
   end

   sar_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q), .tick(tick)
   );

   sar_engine #(.RES_W(RES_W), .FRAME(FRAME)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(go), .abort(!enabled), .tick(tick),
      .cmp_in(cmp_in), .busy(busy), .fin(fin), .code(dac_code), .result(conv_res)
   );

   // result slots
   logic [NCH-1:0][RES_W-1:0] res_a;
   logic [NCH-1:0]            done_v;
   logic [NCH-1:0]            ovr_v;
   logic                      in_res;
   logic [CH_W-1:0]           rsel;

   assign in_res = reg_addr[ADDR_W-1];
   assign rsel   = reg_addr[CH_W-1:0];

   sar_results #(.NCH(NCH), .RES_W(RES_W)) u_res (
      .clk(clk), .rst_n(rst_n),
      .wr_en(fin), .wr_ch(cur_ch), .wr_data(conv_res),
      .clr_en(reg_re && in_res), .clr_ch(rsel),
      .res(res_a), .done(done_v), .ovr(ovr_v)
   );

   assign irq      = |(done_v & imask_q);
   assign chan_sel = cur_ch;

   // read mux
   always_comb begin
      reg_rdata = '0;
      if (in_res) begin
         reg_rdata[RES_W-1:0] = res_a[rsel];
         reg_rdata[R_OVR]     = ovr_v[rsel];
         reg_rdata[R_DONE]    = done_v[rsel];
      end else begin
         case (reg_addr)
            A_CTRL: begin
               reg_rdata[NCH-1:0]            = mask_q;
               reg_rdata[F_DIV_LSB +: DIV_W] = div_q;
               reg_rdata[F_BURST]            = burst_q;
               reg_rdata[F_PON]              = pon_q;
               reg_rdata[F_MODE_LSB +: 2]    = mode_q;
               reg_rdata[F_POL]              = pol_q;
            end
            A_IMASK: reg_rdata[NCH-1:0] = imask_q;
            A_STAT: begin
               reg_rdata[NCH-1:0]        = done_v;
               reg_rdata[S_OVR_LSB +: NCH] = ovr_v;
               reg_rdata[S_BUSY]         = busy;
               reg_rdata[S_IRQ]          = irq;
            end
            default: reg_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
   parameter int NCH   = 8,
   parameter int RES_W = 12,
   localparam int CH_W = $clog2(NCH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwr_gate,
   input logic             pon_q,
   input logic             busy,
   input logic             fin,
   input logic [RES_W-1:0] dac_code,
   input logic [CH_W-1:0]  chan_sel,
   input logic [NCH-1:0]   pick_mask,
   input logic [NCH-1:0]   done_v
);
   // R2
   pon_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_gate |=> !pon_q);

   // R11
   abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pwr_gate && pon_q) |=> !busy);

   // R5
   msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> dac_code == {1'b1, {(RES_W-1){1'b0}}});

   // R7
   chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(chan_sel));

   // R6
   chan_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ((($past(pick_mask) >> chan_sel) & NCH'(1)) != '0));

   // R9
   done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((done_v & ~$past(done_v)) != '0) |-> $past(fin));
endmodule

bind sar_conv_seq sar_conv_seq_chk #(.NCH(NCH), .RES_W(RES_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pwr_gate(pwr_gate), .pon_q(pon_q), .busy(busy),
   .fin(fin), .dac_code(dac_code), .chan_sel(chan_sel), .pick_mask(pick_mask),
   .done_v(done_v)
);

// File: tb/sar_conv_seq_tb.sv
module sar_conv_seq_tb;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_gate = 1'b0;
   logic        reg_we = 1'b0;
   logic        reg_re = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        cmp_in;
   logic [11:0] dac_code;
   logic [2:0]  chan_sel;
   logic        trig_pin = 1'b0;
   logic        trig_match = 1'b0;
   logic        irq;

   // behavioural analog model: one code per channel
   logic [11:0] va [8];

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   assign cmp_in = (va[chan_sel] >= dac_code);

   sar_conv_seq u_dut (
      .clk(clk), .rst_n(rst_n), .pwr_gate(pwr_gate), .reg_we(reg_we), .reg_re(reg_re),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cmp_in(cmp_in), .dac_code(dac_code), .chan_sel(chan_sel),
      .trig_pin(trig_pin), .trig_match(trig_match), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_re = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_re = 1'b0;
   endtask

   task automatic peek(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   function automatic logic [31:0] mk(input logic [7:0] mask, input logic [7:0] n,
                                      input logic burst, input logic pon,
                                      input logic [1:0] mode, input logic pol);
      return {11'b0, pol, mode, pon, burst, n, mask};
   endfunction

   localparam logic [3:0] CTRL = 4'h0, IMASK = 4'h1, STAT = 4'h2;

   initial begin
      #(CLK_P * 200000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [11:0] pats [5];
      pats[0] = 12'h000; pats[1] = 12'hFFF; pats[2] = 12'h800;
      pats[3] = 12'h7FF; pats[4] = 12'h555;
      for (int i = 0; i < 8; i++) va[i] = 12'h000;

      cyc(3);
      rst_n = 1'b1;
      cyc(1);

      // R1 reset state
      peek(CTRL, d); chk("R1 ctrl", d, 32'h0);
      peek(STAT, d); chk("R1 stat", d, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);
      chk("R1 dac", {20'b0, dac_code}, 32'h0);

      // R2 enable refused without the gate
      wr(CTRL, mk(8'h00, 8'd0, 1'b0, 1'b1, 2'b00, 1'b0));
      peek(CTRL, d); chk("R2 pon needs gate", {31'b0, d[17]}, 32'h0);

      // R3 start while inactive is ignored
      pwr_gate = 1'b1;
      va[3] = 12'hA5C;
      wr(CTRL, mk(8'h08, 8'd0, 1'b0, 1'b0, 2'b01, 1'b0));
      cyc(80);
      peek(STAT, d); chk("R3 no conversion when off", d, 32'h0);

      wr(CTRL, mk(8'h00, 8'd0, 1'b0, 1'b1, 2'b00, 1'b0));
      peek(CTRL, d); chk("R2 pon set with gate", {31'b0, d[17]}, 32'h1);

      // R4 R6 timing with N=1, lowest channel of mask 0x28 is 3
      va[5] = 12'h001;
      wr(CTRL, mk(8'h28, 8'd1, 1'b0, 1'b1, 2'b01, 1'b0));
      cyc(65 * 2 - 1);
      peek(STAT, d); chk("R4 not done one clock early", d, 32'h0001_0000);
      cyc(1);
      peek(STAT, d); chk("R4 R6 done on ch3 on time", d, 32'h0000_0008);
      rd(4'd11, d); chk("R5 ch3 result", d, 32'h8000_0A5C);
      peek(STAT, d); chk("R9 read clears done", d, 32'h0);

      // R5 input patterns on ch0
      for (int p = 0; p < 5; p++) begin
         va[0] = pats[p];
         wr(CTRL, mk(8'h01, 8'd0, 1'b0, 1'b1, 2'b01, 1'b0));
         cyc(65);
         rd(4'd8, d); chk("R5 pattern", d, {20'h80000, pats[p]});
      end

      // R4 divider N=3
      wr(CTRL, mk(8'h01, 8'd3, 1'b0, 1'b1, 2'b01, 1'b0));
      cyc(65 * 4 - 1);
      peek(STAT, d); chk("R4 N=3 early", {24'b0, d[7:0]}, 32'h0);
      cyc(1);
      peek(STAT, d); chk("R4 N=3 on time", {24'b0, d[7:0]}, 32'h1);
      rd(4'd8, d);

      // R9 R10 overrun and interrupt on ch1
      va[1] = 12'h123;
      wr(IMASK, 32'h0000_0002);
      wr(CTRL, mk(8'h02, 8'd0, 1'b0, 1'b1, 2'b01, 1'b0));
      cyc(65);
      chk("R10 irq on masked done", {31'b0, irq}, 32'h1);
      wr(CTRL, mk(8'h02, 8'd0, 1'b0, 1'b1, 2'b01, 1'b0));
      cyc(65);
      rd(4'd9, d); chk("R9 overrun on unread result", d, 32'hC000_0123);
      chk("R10 irq low after read", {31'b0, irq}, 32'h0);
      peek(STAT, d); chk("R9 flags cleared", d, 32'h0);

      // R7 burst scan over ch2, ch5, ch7
      va[2] = 12'h222; va[5] = 12'h555; va[7] = 12'h777;
      wr(CTRL, mk(8'hA4, 8'd0, 1'b1, 1'b1, 2'b00, 1'b0));
      cyc(65);
      peek(STAT, d); chk("R7 first conversion busy", d, 32'h0001_0000);
      cyc(1);
      peek(STAT, d); chk("R7 ch2 first", d, 32'h0000_0004);
      chk("R7 chan ch2", {29'b0, chan_sel}, 32'd2);
      cyc(66);
      peek(STAT, d); chk("R7 ch5 second", d, 32'h0000_0024);
      chk("R7 chan ch5", {29'b0, chan_sel}, 32'd5);
      cyc(66);
      peek(STAT, d); chk("R7 ch7 third", d, 32'h0000_00A4);
      chk("R7 chan ch7", {29'b0, chan_sel}, 32'd7);
      cyc(66);
      peek(STAT, d); chk("R7 wrap to ch2", d, 32'h0000_04A4);
      chk("R7 chan wrap", {29'b0, chan_sel}, 32'd2);
      wr(CTRL, mk(8'hA4, 8'd0, 1'b0, 1'b1, 2'b00, 1'b0));
      cyc(80);
      peek(STAT, d); chk("R7 stop after current", d, 32'h0000_24A4);
      rd(4'd10, d); chk("R7 ch2 slot", d, 32'hC000_0222);
      rd(4'd13, d); chk("R7 ch5 slot", d, 32'hC000_0555);
      rd(4'd15, d); chk("R7 ch7 slot", d, 32'h8000_0777);

      // R8 pin trigger, rising edge, second edge while busy ignored
      va[4] = 12'h4A4;
      wr(CTRL, mk(8'h10, 8'd0, 1'b0, 1'b1, 2'b10, 1'b0));
      trig_pin = 1'b1; cyc(10);
      trig_pin = 1'b0; cyc(10);
      trig_pin = 1'b1; cyc(5);
      trig_pin = 1'b0; cyc(80);
      rd(4'd12, d); chk("R8 pin trigger single conversion", d, 32'h8000_04A4);

      // R8 timer trigger, falling edge only
      wr(CTRL, mk(8'h10, 8'd0, 1'b0, 1'b1, 2'b11, 1'b1));
      trig_match = 1'b1; cyc(80);
      peek(STAT, d); chk("R8 rising ignored in falling mode", d, 32'h0);
      trig_match = 1'b0; cyc(80);
      peek(STAT, d); chk("R8 falling edge converts", d, 32'h0000_0010);
      rd(4'd12, d); chk("R8 timer result", d, 32'h8000_04A4);

      // R11 gate removed mid-conversion
      va[6] = 12'h666;
      wr(CTRL, mk(8'h40, 8'd0, 1'b0, 1'b1, 2'b01, 1'b0));
      cyc(20);
      pwr_gate = 1'b0;
      cyc(80);
      peek(STAT, d); chk("R11 no result after abort", d, 32'h0);
      chk("R11 dac idle", {20'b0, dac_code}, 32'h0);
      peek(CTRL, d); chk("R2 gate drop clears pon", {31'b0, d[17]}, 32'h0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule